// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block moves outgoing frames from system memory into a local frame store and hands each completed frame to a byte stream. Software places buffer descriptors in a circular ring and programs the ring's start address. It then pulses the activate input.

From its current position, the walker reads one descriptor after another. It copies the bytes each ready descriptor points at, and writes the descriptor back with its ready flag cleared. A descriptor marked last-in-frame closes the frame, and the assembled bytes are then streamed out. A descriptor marked wrap sends the walk back to the ring start.

The walk ends at the first descriptor that is not ready, or after a fixed number of descriptors. The position reached is kept for the next activation.

Each descriptor occupies two 32-bit words. The first word holds the byte count in bits 15:0, the ready flag in bit 31, the wrap flag in bit 29 and the last-in-frame flag in bit 27. The second word holds the buffer address. Buffer bytes are taken in little-endian order within each word: byte k of a word sits in bits 8k+7:8k. Single-cycle event pulses report each buffer, each frame and each truncation.

Top module: `txr_engine`

## Requirements
- R1: After reset `tx_active`, `mem_req` and `fo_valid` are 0. A `kick` pulse while `ctrl_en` is 1 and the walker is idle sets `tx_active` and starts a read of the descriptor at the current pointer. A `kick` while `ctrl_en` is 0 has no effect: `tx_active` stays 0 and no memory access is made.
- R2: The walker stops on a descriptor whose word-0 bit 31 (ready) is 0. It then clears `tx_active`, and the next activation starts again at that same descriptor address. The buffer address in word 1 must be 4-byte aligned, and its low two bits are ignored.
- R3: Bytes copied from the buffers are streamed out in order on `fo_data` with `fo_valid`, after the walker sees a descriptor with word-0 bit 27 (last) set. `fo_last` marks the final byte, and `ev_txf` pulses in that same cycle. A frame of zero bytes pulses `ev_txf` with no stream bytes.
- R4: Every ready descriptor is written back at its own address with bit 31 cleared and all other bits unchanged, and `ev_txb` pulses once for it.
- R5: After a descriptor with word-0 bit 29 (wrap) set, the next descriptor is read at the ring start. Otherwise it is read 8 bytes further on.
- R6: When the bytes already assembled plus a descriptor's count would exceed `MAX_FRAME`, only the bytes that still fit are copied. `ev_babt` then pulses in the same cycle as that descriptor's `ev_txb`. A count that exactly fills the frame does not pulse `ev_babt`.
- R7: At most `MAX_DESC` descriptors are processed per activation. When that many have been processed, `tx_active` clears and the pointer rests on the following descriptor.
- R8: A `base_wr` pulse stores `base_wdata` as the ring start, with the low 3 bits cleared when `ALIGN8` is 1 and the low 2 bits cleared otherwise. It also loads the current pointer with that value.
- R9: While `ctrl_en` is 0, `tx_active` and `mem_req` are held at 0 and the current pointer is reloaded from the ring start.
- R10: Memory addresses are word aligned. Once `mem_req` is raised, it stays high with the same address and direction until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_en | input | 1 | Controller enable; 0 aborts and rewinds |
| kick | input | 1 | Activate strobe |
| base_wr | input | 1 | Ring start write strobe |
| base_wdata | input | 32 | Ring start write value |
| tx_active | output | 1 | Activation in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory request completed; read data valid |
| mem_rdata | input | 32 | Memory read data |
| fo_valid | output | 1 | Frame byte valid |
| fo_data | output | 8 | Frame byte |
| fo_last | output | 1 | Final byte of the frame |
| ev_txb | output | 1 | Descriptor processed pulse |
| ev_txf | output | 1 | Frame completed pulse |
| ev_babt | output | 1 | Frame truncated pulse |

## Verification
A wrong pointer shows up at the first memory request of the next activation, as a descriptor address that differs from the expected one, and that request appears only a few cycles after `kick`. A wrong assembled length or lane selection shows up on the stream as soon as the frame is emitted, as missing, extra or reordered bytes. A lost ready-flag clear is visible in memory right after the write-back, and it turns into a second walk over the same descriptor on the following activation. A wrong truncation count appears both as an early or late `ev_babt` pulse and as a frame that does not stop at `MAX_FRAME` bytes.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int RDY_BIT  = 31;
  localparam int WRAP_BIT = 29;
  localparam int LAST_BIT = 27;
  localparam logic [31:0] DESC_STEP = 32'd8;
  localparam logic [31:0] WORD_STEP = 32'd4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DESC0,
    S_DESC1,
    S_FETCH,
    S_PUT,
    S_WBACK,
    S_SEND,
    S_NEXT
  } txr_state_e;
endpackage

// File: rtl/txr_frame_ram.sv
module txr_frame_ram #(
  parameter int AW    = 11,
  parameter int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/txr_len_clip.sv
module txr_len_clip #(
  parameter int MAX_FRAME = 2047,
  parameter int FLW       = $clog2(MAX_FRAME + 1)
) (
  input  logic [FLW-1:0] used,
  input  logic [15:0]    want,
  output logic [15:0]    take,
  output logic           over
);
  logic [15:0] room;

  always_comb begin
    room = 16'(MAX_FRAME) - 16'(used);
    over = want > room;
    take = over ? room : want;
  end
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int MAX_FRAME = 2047,
  parameter int MAX_DESC  = 1024,
  parameter bit ALIGN8    = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrl_en,
  input  logic        kick,
  input  logic        base_wr,
  input  logic [31:0] base_wdata,
  output logic        tx_active,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        fo_valid,
  output logic [7:0]  fo_data,
  output logic        fo_last,
  output logic        ev_txb,
  output logic        ev_txf,
  output logic        ev_babt
);
  localparam int AW    = (MAX_FRAME > 1) ? $clog2(MAX_FRAME) : 1;
  localparam int DEPTH = 1 << AW;
  localparam int FLW   = $clog2(MAX_FRAME + 1);
  localparam int CW    = $clog2(MAX_DESC + 1);
  localparam logic [31:0] BASE_MASK = ALIGN8 ? ~32'h7 : ~32'h3;
  localparam logic [31:0] RDY_MASK  = 32'h1 << RDY_BIT;

  txr_state_e     state;
  logic [31:0]    ring_base, cur_ptr, word0, buf_ptr, word_q;
  logic [15:0]    copy_left;
  logic [1:0]     lane;
  logic [FLW-1:0] frame_len, send_len, send_idx;
  logic [CW-1:0]  desc_cnt;
  logic           babt_q;

  logic [15:0]    clip_take;
  logic           clip_over;
  logic [31:0]    nxt_ptr, base_masked;
  logic           ram_we;
  logic [7:0]     ram_wdata;

  txr_len_clip #(.MAX_FRAME(MAX_FRAME), .FLW(FLW)) u_clip (
    .used (frame_len),
    .want (word0[15:0]),
    .take (clip_take),
    .over (clip_over)
  );

  always_comb begin
    nxt_ptr     = word0[WRAP_BIT] ? ring_base : cur_ptr + DESC_STEP;
    base_masked = base_wdata & BASE_MASK;
    ram_we      = (state == S_PUT);
    ram_wdata   = word_q[{lane, 3'b000} +: 8];
  end

  txr_frame_ram #(.AW(AW), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (frame_len[AW-1:0]),
    .wdata (ram_wdata),
    .raddr (send_idx[AW-1:0]),
    .rdata (fo_data)
  );

  always_ff @(posedge clk) begin
    ev_txb   <= 1'b0;
    ev_txf   <= 1'b0;
    ev_babt  <= 1'b0;
    fo_valid <= 1'b0;
    fo_last  <= 1'b0;
    if (rst) begin
      state     <= S_IDLE;
      tx_active <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      ring_base <= '0;
      cur_ptr   <= '0;
      word0     <= '0;
      buf_ptr   <= '0;
      word_q    <= '0;
      copy_left <= '0;
      lane      <= '0;
      frame_len <= '0;
      send_len  <= '0;
      send_idx  <= '0;
      desc_cnt  <= '0;
      babt_q    <= 1'b0;
    end else begin
      if (!ctrl_en) begin
        state     <= S_IDLE;
        tx_active <= 1'b0;
        mem_req   <= 1'b0;
        mem_we    <= 1'b0;
        cur_ptr   <= ring_base;
        frame_len <= '0;
      end else begin
        unique case (state)
          S_IDLE: begin
            if (kick) begin
              tx_active <= 1'b1;
              desc_cnt  <= '0;
              mem_req   <= 1'b1;
              mem_we    <= 1'b0;
              mem_addr  <= cur_ptr;
              state     <= S_DESC0;
            end
          end
          S_DESC0: begin
            if (mem_ack) begin
              mem_req <= 1'b0;
              if (!mem_rdata[RDY_BIT]) begin
                tx_active <= 1'b0;
                state     <= S_IDLE;
              end else begin
                word0    <= mem_rdata;
                mem_req  <= 1'b1;
                mem_addr <= cur_ptr + WORD_STEP;
                state    <= S_DESC1;
              end
            end
          end
          S_DESC1: begin
            if (mem_ack) begin
              mem_req   <= 1'b0;
              copy_left <= clip_take;
              babt_q    <= clip_over;
              if (clip_take != 16'd0) begin
                buf_ptr  <= {mem_rdata[31:2], 2'b00};
                mem_addr <= {mem_rdata[31:2], 2'b00};
                mem_req  <= 1'b1;
                state    <= S_FETCH;
              end else begin
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= cur_ptr;
                mem_wdata <= word0 & ~RDY_MASK;
                state     <= S_WBACK;
              end
            end
          end
          S_FETCH: begin
            if (mem_ack) begin
              mem_req <= 1'b0;
              word_q  <= mem_rdata;
              lane    <= 2'd0;
              state   <= S_PUT;
            end
          end
          S_PUT: begin
            frame_len <= frame_len + FLW'(1);
            copy_left <= copy_left - 16'd1;
            lane      <= lane + 2'd1;
            if (copy_left == 16'd1) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= cur_ptr;
              mem_wdata <= word0 & ~RDY_MASK;
              state     <= S_WBACK;
            end else if (lane == 2'd3) begin
              buf_ptr  <= buf_ptr + WORD_STEP;
              mem_addr <= buf_ptr + WORD_STEP;
              mem_req  <= 1'b1;
              state    <= S_FETCH;
            end
          end
          S_WBACK: begin
            if (mem_ack) begin
              mem_req <= 1'b0;
              mem_we  <= 1'b0;
              ev_txb  <= 1'b1;
              ev_babt <= babt_q;
              if (word0[LAST_BIT]) begin
                frame_len <= '0;
                if (frame_len == '0) begin
                  ev_txf <= 1'b1;
                  state  <= S_NEXT;
                end else begin
                  send_len <= frame_len;
                  send_idx <= '0;
                  state    <= S_SEND;
                end
              end else begin
                state <= S_NEXT;
              end
            end
          end
          S_SEND: begin
            fo_valid <= 1'b1;
            send_idx <= send_idx + FLW'(1);
            if (send_idx == send_len - FLW'(1)) begin
              fo_last <= 1'b1;
              ev_txf  <= 1'b1;
              state   <= S_NEXT;
            end
          end
          S_NEXT: begin
            cur_ptr  <= nxt_ptr;
            desc_cnt <= desc_cnt + CW'(1);
            if (desc_cnt == CW'(MAX_DESC - 1)) begin
              tx_active <= 1'b0;
              state     <= S_IDLE;
            end else begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= nxt_ptr;
              state    <= S_DESC0;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
      if (base_wr) begin
        ring_base <= base_masked;
        cur_ptr   <= base_masked;
      end
    end
  end
endmodule

// File: rtl/txr_checker.sv
module txr_checker (
  input logic        clk,
  input logic        rst,
  input logic        ctrl_en,
  input logic        tx_active,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        wb_ready,
  input logic        mem_ack,
  input logic        fo_valid,
  input logic        fo_last,
  input logic        ev_txb,
  input logic        ev_txf,
  input logic        ev_babt
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && ctrl_en) |=>
      (!ctrl_en || (mem_req && $stable(mem_addr) && $stable(mem_we))));

  assert_word_aligned_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  assert_wb_clears_ready_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !wb_ready);

  assert_babble_with_buffer_R6: assert property (@(posedge clk) disable iff (rst)
    ev_babt |-> ev_txb);

  assert_last_with_frame_R3: assert property (@(posedge clk) disable iff (rst)
    fo_last |-> (fo_valid && ev_txf));

  assert_stream_quiet_bus_R3: assert property (@(posedge clk) disable iff (rst)
    fo_valid |-> !mem_req);

  assert_events_when_active_R1: assert property (@(posedge clk) disable iff (rst)
    (ev_txb || ev_txf) |-> tx_active);

  assert_disable_idles_R9: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> (!tx_active && !mem_req));
endmodule

bind txr_engine txr_checker u_txr_checker (
  .clk       (clk),
  .rst       (rst),
  .ctrl_en   (ctrl_en),
  .tx_active (tx_active),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .wb_ready  (mem_wdata[31]),
  .mem_ack   (mem_ack),
  .fo_valid  (fo_valid),
  .fo_last   (fo_last),
  .ev_txb    (ev_txb),
  .ev_txf    (ev_txf),
  .ev_babt   (ev_babt)
);

// File: tb/test_txr_engine.sv
module test_txr_engine;
  localparam int MAXF  = 64;
  localparam int MAXD  = 16;
  localparam int WDLIM = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_en = 1'b0;
  logic        kick = 1'b0;
  logic        base_wr = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        tx_active, mem_req, mem_we, fo_valid, fo_last;
  logic        ev_txb, ev_txf, ev_babt;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [7:0]  fo_data;

  always #4 clk = ~clk;

  txr_engine #(.MAX_FRAME(MAXF), .MAX_DESC(MAXD), .ALIGN8(1'b1)) i_txr_engine (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .kick(kick),
    .base_wr(base_wr), .base_wdata(base_wdata), .tx_active(tx_active),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .fo_valid(fo_valid), .fo_data(fo_data), .fo_last(fo_last),
    .ev_txb(ev_txb), .ev_txf(ev_txf), .ev_babt(ev_babt)
  );

  logic [31:0] mem [0:4095];
  logic [31:0] rd_log [0:8191];
  logic [7:0]  cap [0:4095];
  logic [7:0]  exp_bytes [0:1023];
  int n_rd = 0, n_cap = 0, n_frm = 0, c_txb = 0, c_txf = 0, c_babt = 0;
  int lat = 0;
  int n_chk = 0, n_fail = 0;
  int n_exp, exp_flen, e_txb, e_txf, e_babt;
  int s_cap, s_frm, s_txb, s_txf, s_babt, s_rd;
  bit align_bad = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0;
      lat = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (lat == 0) begin
        mem_ack = 1'b1;
        if (mem_addr[1:0] != 2'b00) align_bad = 1'b1;
        if (mem_we) mem[mem_addr[13:2]] = mem_wdata;
        else begin
          mem_rdata = mem[mem_addr[13:2]];
          rd_log[n_rd] = mem_addr;
          n_rd++;
        end
        lat = int'($urandom % 3);
      end else lat--;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (fo_valid) begin
        cap[n_cap] = fo_data;
        n_cap++;
        if (fo_last) n_frm++;
      end
      if (ev_txb) c_txb++;
      if (ev_txf) c_txf++;
      if (ev_babt) c_babt++;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] byte_at(input logic [31:0] a);
    return mem[a[13:2]][{a[1:0], 3'b000} +: 8];
  endfunction

  function automatic logic [31:0] dword0(input int len, input bit rdy, input bit wrap, input bit last);
    return {rdy, 1'b0, wrap, 1'b0, last, 11'b0, 16'(len)};
  endfunction

  task automatic put_desc(input logic [31:0] a, input int len, input bit rdy,
                          input bit wrap, input bit last, input logic [31:0] b);
    mem[a[13:2]] = dword0(len, rdy, wrap, last);
    mem[a[13:2] + 12'd1] = b;
    for (int w = 0; w < (len + 3) / 4; w++) mem[b[13:2] + 12'(w)] = $urandom;
  endtask

  task automatic start_scn();
    s_cap = n_cap; s_frm = n_frm; s_txb = c_txb; s_txf = c_txf;
    s_babt = c_babt; s_rd = n_rd;
    n_exp = 0; exp_flen = 0; e_txb = 0; e_txf = 0; e_babt = 0;
  endtask

  task automatic exp_desc(input int len, input logic [31:0] b, input bit last);
    int take;
    take = len;
    if (exp_flen + len > MAXF) begin
      take = MAXF - exp_flen;
      e_babt++;
    end
    for (int k = 0; k < take; k++) begin
      exp_bytes[n_exp] = byte_at(b + 32'(k));
      n_exp++;
    end
    exp_flen += take;
    e_txb++;
    if (last) begin
      e_txf++;
      exp_flen = 0;
    end
  endtask

  task automatic compare(input string req);
    int bad;
    bad = -1;
    check(n_cap - s_cap == n_exp, req, n_cap - s_cap, n_exp);
    for (int k = 0; k < n_exp && k < n_cap - s_cap; k++)
      if (bad < 0 && cap[s_cap + k] != exp_bytes[k]) bad = k;
    if (bad >= 0) check(1'b0, req, cap[s_cap + bad], exp_bytes[bad]);
    else check(1'b1, req, 0, 0);
    check(c_txb - s_txb == e_txb, "R4 ev_txb count", c_txb - s_txb, e_txb);
    check(c_txf - s_txf == e_txf, "R3 ev_txf count", c_txf - s_txf, e_txf);
    check(c_babt - s_babt == e_babt, "R6 ev_babt count", c_babt - s_babt, e_babt);
  endtask

  task automatic base_write(input logic [31:0] v);
    @(negedge clk); base_wr = 1'b1; base_wdata = v;
    @(negedge clk); base_wr = 1'b0;
  endtask

  task automatic kick_wait();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    while (tx_active) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (WDLIM) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tx_active == 1'b0, "R1 reset tx_active", tx_active, 0);
    check(mem_req == 1'b0, "R1 reset mem_req", mem_req, 0);
    check(fo_valid == 1'b0, "R1 reset fo_valid", fo_valid, 0);
    ctrl_en = 1'b1;

    // R8 alignment, R3 two-buffer frame, R2 stop on not ready
    base_write(32'h105);
    start_scn();
    put_desc(32'h100, 5, 1, 0, 0, 32'h2000);
    put_desc(32'h108, 3, 1, 0, 1, 32'h2080);
    put_desc(32'h110, 2, 0, 0, 1, 32'h2100);
    exp_desc(5, 32'h2000, 0);
    exp_desc(3, 32'h2080, 1);
    kick_wait();
    check(rd_log[s_rd] == 32'h100, "R8 first fetch aligned", rd_log[s_rd], 32'h100);
    check(rd_log[n_rd-1] == 32'h110, "R2 stop descriptor", rd_log[n_rd-1], 32'h110);
    check(mem[32'h100 >> 2] == dword0(5, 0, 0, 0), "R4 write-back d0", mem[32'h100 >> 2], dword0(5, 0, 0, 0));
    check(mem[32'h108 >> 2] == dword0(3, 0, 0, 1), "R4 write-back d1", mem[32'h108 >> 2], dword0(3, 0, 0, 1));
    check(n_frm - s_frm == 1, "R3 frame count", n_frm - s_frm, 1);
    compare("R3 stream");

    // R2 pointer kept, R5 wrap to ring start
    start_scn();
    put_desc(32'h110, 2, 1, 1, 1, 32'h2100);
    exp_desc(2, 32'h2100, 1);
    kick_wait();
    check(rd_log[s_rd] == 32'h110, "R2 resume pointer", rd_log[s_rd], 32'h110);
    check(rd_log[n_rd-1] == 32'h100, "R5 wrap target", rd_log[n_rd-1], 32'h100);
    compare("R5 stream");

    // R1 kick ignored while disabled, R9 rewind on disable
    start_scn();
    put_desc(32'h100, 4, 1, 0, 1, 32'h2000);
    put_desc(32'h108, 0, 0, 0, 0, 32'h2080);
    exp_desc(4, 32'h2000, 1);
    kick_wait();
    compare("R3 single buffer");
    put_desc(32'h108, 2, 1, 0, 1, 32'h2080);
    @(negedge clk); ctrl_en = 1'b0;
    s_rd = n_rd; s_cap = n_cap;
    kick_wait();
    repeat (6) @(negedge clk);
    check(tx_active == 1'b0, "R1 kick while disabled", tx_active, 0);
    check(n_rd == s_rd, "R1 no fetch while disabled", n_rd - s_rd, 0);
    check(n_cap == s_cap, "R1 no stream while disabled", n_cap - s_cap, 0);
    ctrl_en = 1'b1;
    start_scn();
    kick_wait();
    check(n_rd - s_rd == 1, "R9 single fetch after rewind", n_rd - s_rd, 1);
    check(rd_log[s_rd] == 32'h100, "R9 rewound pointer", rd_log[s_rd], 32'h100);

    // R6 truncation, then exact fill without babble
    base_write(32'h304);
    start_scn();
    put_desc(32'h300, 40, 1, 0, 0, 32'h2000);
    put_desc(32'h308, 40, 1, 1, 1, 32'h2080);
    exp_desc(40, 32'h2000, 0);
    exp_desc(40, 32'h2080, 1);
    kick_wait();
    check(rd_log[s_rd] == 32'h300, "R8 second base", rd_log[s_rd], 32'h300);
    compare("R6 truncated frame");
    start_scn();
    put_desc(32'h300, 64, 1, 0, 1, 32'h2000);
    put_desc(32'h308, 0, 0, 0, 0, 32'h2080);
    exp_desc(64, 32'h2000, 1);
    kick_wait();
    compare("R6 exact fill");

    // R7 descriptor limit per activation
    base_write(32'h800);
    start_scn();
    for (int i = 0; i < 20; i++)
      put_desc(32'h800 + 32'(8 * i), 1, 1, 0, 1, 32'h2000 + 32'(128 * i));
    put_desc(32'h800 + 32'd160, 0, 0, 0, 0, 32'h2000);
    for (int i = 0; i < MAXD; i++) exp_desc(1, 32'h2000 + 32'(128 * i), 1);
    kick_wait();
    check(n_frm - s_frm == MAXD, "R7 frames first activation", n_frm - s_frm, MAXD);
    compare("R7 first activation");
    start_scn();
    for (int i = MAXD; i < 20; i++) exp_desc(1, 32'h2000 + 32'(128 * i), 1);
    kick_wait();
    check(rd_log[s_rd] == 32'h800 + 32'(8 * MAXD), "R7 resume after limit", rd_log[s_rd], 32'h800 + 32'(8 * MAXD));
    compare("R7 second activation");

    // Random rings
    for (int r = 0; r < 8; r++) begin
      int nd;
      base_write(32'hC00 | ($urandom % 8));
      start_scn();
      nd = 1 + int'($urandom % 6);
      for (int i = 0; i < nd; i++) begin
        int len;
        bit last;
        len  = int'($urandom % 30);
        last = (i == nd - 1) || ($urandom % 3 == 0);
        put_desc(32'hC00 + 32'(8 * i), len, 1, i == nd - 1, last, 32'h2000 + 32'(128 * i));
        exp_desc(len, 32'h2000 + 32'(128 * i), last);
      end
      kick_wait();
      check(rd_log[n_rd-1] == 32'hC00, "R5 random wrap stop", rd_log[n_rd-1], 32'hC00);
      compare("R3 random ring");
    end
    check(align_bad == 1'b0, "R10 word aligned addresses", align_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule